// File: doc/BRIEF.md
# Lock-Gated Reset Release Sequencer

This block orders how resets leave a memory-interface clocking chain. A global user-logic reset (asynchronous, active high) restarts it. Two cascaded clock generators each report lock, and an input-delay calibration controller reports ready. The sequencer releases four active-high resets in a fixed order: the first clock generator, the second clock generator, the delay calibration controller, and last the memory controller datapath. Each release waits for the upstream condition to be seen, synchronised into the sequencer clock. Every lock-gated release also waits for a minimum number of cycles with that lock held.

While the datapath reset is asserted, the command lines toward the memory are forced to a no-operation code. A reset or an unstable clock chain therefore cannot present a write. If either lock drops after the sequence has relied on it, the whole sequence starts again from the beginning. A flag reports when the datapath has been held in reset longer than a configurable bound, so that missed refresh can be detected.

All resets are asserted asynchronously by the global reset and are released only on a sequencer clock edge.

Top module: `lock_reset_seq`

## Requirements
- R1: While `globalRst` is high, `genARst`, `genBRst`, `dlyCtrlRst` and `dpRst` are 1, `seqDone` and `holdOverrun` are 0, and `cmdOut` is the no-operation code 3'b111.
- R2: After `globalRst` falls, `genARst` stays 1 for MIN_HOLD rising edges and drops at the MIN_HOLD-th edge.
- R3: Each lock and ready input passes through a two-stage synchroniser. `genBRst` drops only after the synchronised `lockA` has been high on MIN_HOLD consecutive edges. A shorter high pulse does not release it.
- R4: `dlyCtrlRst` drops only after the synchronised `lockB` has been high on MIN_HOLD consecutive edges while `lockA` stays high.
- R5: Once the delay controller reset is released, `dpRst` drops and `seqDone` rises on the edge at which the synchronised `dlyRdy` is first seen high, provided both locks are still high.
- R6: If synchronised `lockA` goes low after `genBRst` was released, or synchronised `lockB` goes low after `dlyCtrlRst` was released, all four resets return to 1 on that edge and the sequence restarts from R2.
- R7: `cmdOut` bits are {row strobe_n, column strobe_n, write enable_n}. The write code is 3'b100. While `dpRst` is 1, `cmdOut` is 3'b111 whatever `cmdIn` carries. Otherwise `cmdOut` equals `cmdIn`.
- R8: `holdOverrun` rises once `dpRst` has been 1 for MAX_HOLD consecutive edges since `globalRst` fell or since the last time the block was running. It returns to 0 on the edge at which `dpRst` drops.
- R9: Raising `globalRst` at any moment asserts all resets at once, without waiting for a clock edge. When it falls again, the full sequence of R2 to R5 repeats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock, free running |
| globalRst | input | 1 | Asynchronous global reset, active high |
| lockA | input | 1 | Lock indication of the first clock generator (asynchronous) |
| lockB | input | 1 | Lock indication of the second, cascaded clock generator (asynchronous) |
| dlyRdy | input | 1 | Ready indication of the delay calibration controller (asynchronous) |
| cmdIn | input | 3 | Memory command from the controller {ras_n, cas_n, we_n} |
| genARst | output | 1 | Reset of the first clock generator |
| genBRst | output | 1 | Reset of the second clock generator |
| dlyCtrlRst | output | 1 | Reset of the delay calibration controller |
| dpRst | output | 1 | Reset of the memory controller datapath |
| seqDone | output | 1 | High while the sequence is complete and running |
| holdOverrun | output | 1 | Datapath reset held beyond MAX_HOLD cycles |
| cmdOut | output | 3 | Command toward the memory, no-operation while in reset |

## Verification
The bench drives a lock pulse that is shorter than the minimum hold. A design that released on the first sight of lock would free the second generator too early. Locks are dropped in the middle of the sequence and while running. A design that failed to restart would leave the delay controller or datapath running on an unstable clock. The global reset is raised away from any clock edge, which exposes a design whose assertion waits for a clock. Command codes cycle through every value, including the write code, both during reset and while running. A leaked write or a blocked command shows up at once. A long lock stall drives the overrun bound, and the bench then checks that the flag is raised and later cleared.

// File: rtl/lrs_pkg.sv
package lrs_pkg;

  localparam int NUM_RST = 4;
  localparam int IDX_GEN_A = 0;
  localparam int IDX_GEN_B = 1;
  localparam int IDX_DLY   = 2;
  localparam int IDX_DP    = 3;

  localparam int CMD_W = 3;
  localparam logic [CMD_W-1:0] CMD_NOP   = 3'b111;
  localparam logic [CMD_W-1:0] CMD_WRITE = 3'b100;

  typedef enum logic [2:0] {
    ST_HOLD_ALL,
    ST_WAIT_GEN_A,
    ST_WAIT_GEN_B,
    ST_WAIT_DELAY,
    ST_RUN
  } seq_state_t;

  typedef struct packed {
    logic [NUM_RST-1:0] holdRst;
  } seq_strobe_t;

endpackage

// File: rtl/lrs_sync.sv
module lrs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic clr,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or posedge clr) begin
    if (clr) chain <= '0;
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/lrs_ctrl.sv
module lrs_ctrl
  import lrs_pkg::*;
#(
  parameter int MIN_HOLD    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        globalRst,
  input  logic        lockA,
  input  logic        lockB,
  input  logic        dlyRdy,
  output seq_strobe_t strobe,
  output logic        seqDone
);

  localparam int NUM_IN = 3;
  localparam int HW = (MIN_HOLD > 1) ? $clog2(MIN_HOLD) : 1;
  localparam logic [HW-1:0] HOLD_LAST = HW'(MIN_HOLD - 1);

  logic [NUM_IN-1:0] rawIn;
  logic [NUM_IN-1:0] syncIn;
  logic lockASync, lockBSync, dlyRdySync;

  assign rawIn = {dlyRdy, lockB, lockA};

  for (genvar g = 0; g < NUM_IN; g++) begin : g_sync
    lrs_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .clr  (globalRst),
      .din  (rawIn[g]),
      .dout (syncIn[g])
    );
  end

  assign lockASync  = syncIn[0];
  assign lockBSync  = syncIn[1];
  assign dlyRdySync = syncIn[2];

  seq_state_t state, nextState;
  logic [HW-1:0] holdCnt;
  logic condMet, holdMet;

  always_comb begin
    case (state)
      ST_WAIT_GEN_A: condMet = lockASync;
      ST_WAIT_GEN_B: condMet = lockBSync;
      default:       condMet = 1'b1;
    endcase
  end

  assign holdMet = condMet && (holdCnt == HOLD_LAST);

  always_comb begin
    nextState = state;
    case (state)
      ST_HOLD_ALL:   if (holdMet) nextState = ST_WAIT_GEN_A;
      ST_WAIT_GEN_A: if (holdMet) nextState = ST_WAIT_GEN_B;
      ST_WAIT_GEN_B: begin
        if (!lockASync)   nextState = ST_HOLD_ALL;
        else if (holdMet) nextState = ST_WAIT_DELAY;
      end
      ST_WAIT_DELAY: begin
        if (!lockASync || !lockBSync) nextState = ST_HOLD_ALL;
        else if (dlyRdySync)          nextState = ST_RUN;
      end
      ST_RUN: if (!lockASync || !lockBSync) nextState = ST_HOLD_ALL;
      default: nextState = ST_HOLD_ALL;
    endcase
  end

  always_ff @(posedge clk or posedge globalRst) begin
    if (globalRst) begin
      state   <= ST_HOLD_ALL;
      holdCnt <= '0;
    end else begin
      state <= nextState;
      if ((nextState != state) || !condMet) holdCnt <= '0;
      else                                  holdCnt <= holdCnt + HW'(1);
    end
  end

  always_comb begin
    strobe.holdRst[IDX_GEN_A] = (nextState == ST_HOLD_ALL);
    strobe.holdRst[IDX_GEN_B] = (nextState == ST_HOLD_ALL) || (nextState == ST_WAIT_GEN_A);
    strobe.holdRst[IDX_DLY]   = (nextState != ST_WAIT_DELAY) && (nextState != ST_RUN);
    strobe.holdRst[IDX_DP]    = (nextState != ST_RUN);
  end

  assign seqDone = (state == ST_RUN);

  // R3
  genb_gate_chk: assert property (@(posedge clk) disable iff (globalRst)
    (state == ST_WAIT_GEN_B) |-> $past(lockASync));

  // R5
  run_gate_chk: assert property (@(posedge clk) disable iff (globalRst)
    (state == ST_RUN) |-> ($past(lockASync) && $past(lockBSync)));

endmodule

// File: rtl/lrs_datapath.sv
module lrs_datapath
  import lrs_pkg::*;
#(
  parameter int MAX_HOLD = 1024
) (
  input  logic               clk,
  input  logic               globalRst,
  input  seq_strobe_t        strobe,
  input  logic [CMD_W-1:0]   cmdIn,
  output logic [NUM_RST-1:0] rstOut,
  output logic               holdOverrun,
  output logic [CMD_W-1:0]   cmdOut
);

  localparam int OW = $clog2(MAX_HOLD + 1);
  localparam logic [OW-1:0] OVER_LIMIT = OW'(MAX_HOLD);

  for (genvar r = 0; r < NUM_RST; r++) begin : g_rst
    logic rstQ;
    always_ff @(posedge clk or posedge globalRst) begin
      if (globalRst) rstQ <= 1'b1;
      else           rstQ <= strobe.holdRst[r];
    end
    assign rstOut[r] = rstQ;
  end

  logic [OW-1:0] overCnt;

  always_ff @(posedge clk or posedge globalRst) begin
    if (globalRst)                   overCnt <= '0;
    else if (!strobe.holdRst[IDX_DP]) overCnt <= '0;
    else if (overCnt != OVER_LIMIT)  overCnt <= overCnt + OW'(1);
  end

  assign holdOverrun = (overCnt == OVER_LIMIT);
  assign cmdOut      = rstOut[IDX_DP] ? CMD_NOP : cmdIn;

  // R3
  genb_after_gena_chk: assert property (@(posedge clk) disable iff (globalRst)
    !rstOut[IDX_GEN_B] |-> !rstOut[IDX_GEN_A]);

  // R4
  dly_after_genb_chk: assert property (@(posedge clk) disable iff (globalRst)
    !rstOut[IDX_DLY] |-> !rstOut[IDX_GEN_B]);

  // R5
  dp_after_dly_chk: assert property (@(posedge clk) disable iff (globalRst)
    !rstOut[IDX_DP] |-> !rstOut[IDX_DLY]);

  // R7
  no_write_chk: assert property (@(posedge clk) disable iff (globalRst)
    rstOut[IDX_DP] |-> (cmdOut != CMD_WRITE));

  // R8
  overrun_scope_chk: assert property (@(posedge clk) disable iff (globalRst)
    holdOverrun |-> rstOut[IDX_DP]);

endmodule

// File: rtl/lock_reset_seq.sv
module lock_reset_seq #(
  parameter int MIN_HOLD    = 16,
  parameter int MAX_HOLD    = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       globalRst,
  input  logic       lockA,
  input  logic       lockB,
  input  logic       dlyRdy,
  input  logic [2:0] cmdIn,
  output logic       genARst,
  output logic       genBRst,
  output logic       dlyCtrlRst,
  output logic       dpRst,
  output logic       seqDone,
  output logic       holdOverrun,
  output logic [2:0] cmdOut
);

  lrs_pkg::seq_strobe_t strobe;
  logic [lrs_pkg::NUM_RST-1:0] rstOut;

  lrs_ctrl #(.MIN_HOLD(MIN_HOLD), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk       (clk),
    .globalRst (globalRst),
    .lockA     (lockA),
    .lockB     (lockB),
    .dlyRdy    (dlyRdy),
    .strobe    (strobe),
    .seqDone   (seqDone)
  );

  lrs_datapath #(.MAX_HOLD(MAX_HOLD)) u_dp (
    .clk         (clk),
    .globalRst   (globalRst),
    .strobe      (strobe),
    .cmdIn       (cmdIn),
    .rstOut      (rstOut),
    .holdOverrun (holdOverrun),
    .cmdOut      (cmdOut)
  );

  assign genARst    = rstOut[lrs_pkg::IDX_GEN_A];
  assign genBRst    = rstOut[lrs_pkg::IDX_GEN_B];
  assign dlyCtrlRst = rstOut[lrs_pkg::IDX_DLY];
  assign dpRst      = rstOut[lrs_pkg::IDX_DP];

endmodule

// File: tb/lock_reset_seq_tb_top.sv
module lock_reset_seq_tb_top;

  localparam int MIN_HOLD = 4;
  localparam int MAX_HOLD = 60;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic globalRst = 1'b0;
  logic lockA = 1'b0, lockB = 1'b0, dlyRdy = 1'b0;
  logic [2:0] cmdIn = 3'd0;
  logic genARst, genBRst, dlyCtrlRst, dpRst, seqDone, holdOverrun;
  logic [2:0] cmdOut;

  lock_reset_seq #(.MIN_HOLD(MIN_HOLD), .MAX_HOLD(MAX_HOLD)) dut_i (
    .clk(clk), .globalRst(globalRst), .lockA(lockA), .lockB(lockB), .dlyRdy(dlyRdy),
    .cmdIn(cmdIn), .genARst(genARst), .genBRst(genBRst), .dlyCtrlRst(dlyCtrlRst),
    .dpRst(dpRst), .seqDone(seqDone), .holdOverrun(holdOverrun), .cmdOut(cmdOut)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Reference model: phase 0 hold all, 1 wait lock A, 2 wait lock B,
  // 3 wait delay ready, 4 running.
  int phase = 0, streak = 0, ovCnt = 0, np = 0, cond = 0;
  int a0 = 0, a1 = 0, b0 = 0, b1 = 0, r0 = 0, r1 = 0;

  always @(posedge clk) begin
    if (globalRst) begin
      phase = 0; streak = 0; ovCnt = 0;
      a0 = 0; a1 = 0; b0 = 0; b1 = 0; r0 = 0; r1 = 0;
    end else begin
      np = phase;
      cond = (phase == 0) ? 1 : (phase == 1) ? a1 : (phase == 2) ? b1 : 0;
      streak = cond ? streak + 1 : 0;
      if (phase == 0 && streak >= MIN_HOLD) np = 1;
      else if (phase == 1 && streak >= MIN_HOLD) np = 2;
      else if (phase == 2) begin
        if (a1 == 0) np = 0;
        else if (streak >= MIN_HOLD) np = 3;
      end else if (phase == 3) begin
        if (a1 == 0 || b1 == 0) np = 0;
        else if (r1 != 0) np = 4;
      end else if (phase == 4) begin
        if (a1 == 0 || b1 == 0) np = 0;
      end
      if (np != phase) streak = 0;
      phase = np;
      if (phase != 4) ovCnt = (ovCnt < MAX_HOLD) ? ovCnt + 1 : MAX_HOLD;
      else ovCnt = 0;
      a1 = a0; a0 = int'(lockA);
      b1 = b0; b0 = int'(lockB);
      r1 = r0; r0 = int'(dlyRdy);
    end
  end

  // Compare on every clock, away from the active edge.
  always @(negedge clk) begin
    if (!finished) begin
      if (globalRst) begin
        chk("R1", "genARst", int'(genARst), 1);
        chk("R1", "dpRst", int'(dpRst), 1);
        chk("R1", "cmdOut", int'(cmdOut), 7);
      end else begin
        chk("R2", "genARst", int'(genARst), (phase == 0) ? 1 : 0);
        chk("R3", "genBRst", int'(genBRst), (phase <= 1) ? 1 : 0);
        chk("R4", "dlyCtrlRst", int'(dlyCtrlRst), (phase <= 2) ? 1 : 0);
        chk("R5", "dpRst", int'(dpRst), (phase <= 3) ? 1 : 0);
        chk("R5", "seqDone", int'(seqDone), (phase == 4) ? 1 : 0);
        chk("R7", "cmdOut", int'(cmdOut), (phase <= 3) ? 7 : int'(cmdIn));
        chk("R8", "holdOverrun", int'(holdOverrun), (ovCnt == MAX_HOLD) ? 1 : 0);
      end
    end
  end

  // Command stream covering every code, write included.
  always begin
    @(negedge clk);
    #3;
    cmdIn = cmdIn + 3'd3;
  end

  task automatic step(input int n);
    repeat (n) begin
      @(negedge clk);
      #2;
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin
    #1 globalRst = 1'b1;
    step(3);
    chk("R1", "genBRst in reset", int'(genBRst), 1);
    chk("R1", "dlyCtrlRst in reset", int'(dlyCtrlRst), 1);
    chk("R1", "seqDone in reset", int'(seqDone), 0);
    chk("R1", "holdOverrun in reset", int'(holdOverrun), 0);

    globalRst = 1'b0;
    step(MIN_HOLD - 1);
    chk("R2", "genARst before hold ends", int'(genARst), 1);
    step(1);
    chk("R2", "genARst at hold end", int'(genARst), 0);

    // Short lock pulse must not release generator B.
    lockA = 1'b1; step(2); lockA = 1'b0; step(10);
    chk("R3", "genBRst after short lock pulse", int'(genBRst), 1);

    lockA = 1'b1;
    step(1 + MIN_HOLD);
    chk("R3", "genBRst one edge early", int'(genBRst), 1);
    step(1);
    chk("R3", "genBRst released", int'(genBRst), 0);

    // Drop lock A while waiting for lock B.
    step(2);
    lockA = 1'b0;
    step(3);
    chk("R6", "genARst after lockA loss", int'(genARst), 1);
    chk("R6", "genBRst after lockA loss", int'(genBRst), 1);

    // Long stall: overrun bound.
    step(MAX_HOLD);
    chk("R8", "holdOverrun during stall", int'(holdOverrun), 1);

    lockA = 1'b1; lockB = 1'b1;
    for (int i = 0; i < 400 && dlyCtrlRst; i++) step(1);
    chk("R4", "dlyCtrlRst released", int'(dlyCtrlRst), 0);
    step(3);
    chk("R5", "dpRst held without ready", int'(dpRst), 1);
    dlyRdy = 1'b1;
    step(2);
    chk("R5", "dpRst before ready synchronised", int'(dpRst), 1);
    step(1);
    chk("R5", "dpRst released", int'(dpRst), 0);
    chk("R5", "seqDone high", int'(seqDone), 1);
    chk("R8", "holdOverrun cleared", int'(holdOverrun), 0);

    step(20);
    chk("R7", "cmdOut passes while running", int'(cmdOut), int'(cmdIn));

    // Drop lock B while running.
    lockB = 1'b0;
    step(3);
    chk("R6", "genARst after lockB loss", int'(genARst), 1);
    chk("R6", "dpRst after lockB loss", int'(dpRst), 1);
    chk("R7", "cmdOut forced to no-op", int'(cmdOut), 7);
    lockB = 1'b1;
    for (int i = 0; i < 400 && !seqDone; i++) step(1);
    chk("R6", "sequence completes again", int'(seqDone), 1);

    // Global reset off any clock edge.
    step(5);
    #1 globalRst = 1'b1;
    #1;
    chk("R9", "genARst asynchronous", int'(genARst), 1);
    chk("R9", "dpRst asynchronous", int'(dpRst), 1);
    chk("R9", "seqDone asynchronous", int'(seqDone), 0);
    chk("R9", "cmdOut asynchronous", int'(cmdOut), 7);
    step(2);
    globalRst = 1'b0;
    for (int i = 0; i < 400 && !seqDone; i++) step(1);
    chk("R9", "sequence repeats after reset", int'(seqDone), 1);
    step(5);

    finished = 1;
    summary();
    $finish;
  end

endmodule